// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read

This block is a first-in first-out buffer for 9-bit words whose write port and read port run on two unrelated clocks. Storage is a small power-of-two array written on the write clock. Write and read pointers cross between the domains as Gray code through chains of synchroniser flops. The full, half-full and almost-full flags are worked out on the write side. The empty, output-ready and almost-empty flags are worked out on the read side.

A static mode input, changed only while master reset is held, picks one of two read behaviours. In standard mode the output register loads a word only when a read is requested. In fall-through mode the head word moves into the output register without any request, so the output register counts as one extra word of capacity. In both modes the same two status pins are used, with a meaning that depends on the mode.

Two resets are provided. The asynchronous master reset loads the almost-empty and almost-full offsets from parameters. The synchronous partial reset empties the buffer and sets the flags, but leaves the offsets as they are.

Top module: `dual_clock_fifo`

## Requirements
- R1: With `fwft`=0, `rd_stat_n` is 0 exactly when no word is stored, and `wr_stat_n` is 0 exactly when DEPTH words are stored.
- R2: With `fwft`=0, a read-clock edge with `ren`=1 while words are stored loads the oldest word into `rdata`, and words come out in write order. With `ren`=0, `rdata` holds its value.
- R3: With `fwft`=0, `ren`=1 while `rd_stat_n`=0 does nothing: `rdata` keeps its last word and the flags do not change.
- R4: With `fwft`=0, after a write into an empty buffer, `rd_stat_n` rises on the 3rd read-clock edge after the write edge, or on the 4th edge if the two edges fall close together.
- R5: With `fwft`=1, the first word written into an empty buffer appears on `rdata` with no read request. `rd_stat_n` falls on the 4th or 5th read-clock edge after the write edge. Each `ren` edge while `rd_stat_n`=0 removes the shown word.
- R6: With `fwft`=1, the buffer holds DEPTH+1 words. `wr_stat_n` is 1 (input not ready) once DEPTH+1 words are held, and is 0 otherwise.
- R7: A write while the buffer is full is dropped. The word never appears on the read side and the buffer contents are unchanged.
- R8: `half_full` is 1 when the array holds more than DEPTH/2 words.
- R9: `almost_full` is 1 when the array holds at least DEPTH-AF_OFS words.
- R10: `almost_empty` is 1 when the total count, including a valid fall-through output word, is AE_OFS or less, and 0 when it is above AE_OFS.
- R11: After `prst_n` is held low, the buffer is empty. `almost_empty`=1, `half_full`=0 and `almost_full`=0. `rd_stat_n` equals `fwft` and `wr_stat_n` equals the inverse of `fwft`. The offsets are kept.
- R12: After master reset the flags take the same values as in R11, and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Asynchronous master reset, active low; loads the offsets |
| prst_n | input | 1 | Partial reset, active low, sampled in each domain |
| fwft | input | 1 | Read mode: 0 = standard, 1 = fall-through; static outside reset |
| wen | input | 1 | Write request |
| wdata | input | 9 | Write word |
| ren | input | 1 | Read request |
| rdata | output | 9 | Output register |
| rd_stat_n | output | 1 | Standard: empty, active low. Fall-through: output ready, active low |
| wr_stat_n | output | 1 | Standard: full, active low. Fall-through: input ready, active low |
| almost_empty | output | 1 | Total count at or below AE_OFS |
| half_full | output | 1 | Array count above DEPTH/2 |
| almost_full | output | 1 | Array count at or above DEPTH-AF_OFS |

## Verification
Read-side flags change on the 3rd read edge after a write (4th in fall-through mode), because a write passes through two synchroniser stages and then one flag register. One extra edge is allowed when the clocks nearly line up. The bench counts read edges after each write edge and accepts either of the two values. A read result shows up on the same read edge that takes the request, so the bench samples it at the next falling edge. Level checks for the thresholds and for the state after reset are made only after a settling wait of ten edges in each domain, which is longer than any path through the synchronisers.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;

  typedef enum logic {
    RD_STANDARD = 1'b0,
    RD_FALLTHRU = 1'b1
  } rd_mode_e;

  // strict threshold: count above limit
  function automatic logic above(input int unsigned cnt, input int unsigned lim);
    return cnt > lim;
  endfunction

  // inclusive threshold: count at or above limit
  function automatic logic at_least(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
module dcfifo_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg <= '0;
    end else if (!clr_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcfifo_ram.sv
`timescale 1ns/1ps
module dcfifo_ram #(
  parameter int unsigned DW    = 9,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
`timescale 1ns/1ps
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned AW     = 4,
  parameter int unsigned AF_OFS = 4
) (
  input  logic        wclk,
  input  logic        mrst_n,
  input  logic        prst_n,
  input  logic        wen,
  input  logic [AW:0] rgray_s,
  output logic        accept,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray,
  output logic [AW:0] wbin,
  output logic        full,
  output logic        half_full,
  output logic        almost_full
);
  localparam int unsigned PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin_q, wgray_q, rbin_s, wbin_nx, wcnt_nx, m_off_q;
  logic          full_q, hf_q, af_q;

  always_comb begin
    accept  = wen && !full_q;
    rbin_s  = from_gray(rgray_s);
    wbin_nx = wbin_q + PW'(accept);
    wcnt_nx = wbin_nx - rbin_s;
  end

  always_ff @(posedge wclk or negedge mrst_n) begin
    if (!mrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      hf_q    <= 1'b0;
      af_q    <= 1'b0;
      m_off_q <= PW'(AF_OFS);
    end else if (!prst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      hf_q    <= 1'b0;
      af_q    <= 1'b0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= to_gray(wbin_nx);
      full_q  <= at_least(32'(wcnt_nx), DEPTH);
      hf_q    <= above(32'(wcnt_nx), DEPTH / 2);
      af_q    <= at_least(32'(wcnt_nx), DEPTH - 32'(m_off_q));
    end
  end

  assign waddr       = wbin_q[AW-1:0];
  assign wgray       = wgray_q;
  assign wbin        = wbin_q;
  assign full        = full_q;
  assign half_full   = hf_q;
  assign almost_full = af_q;
endmodule

// File: rtl/dcfifo_rd_ctl.sv
`timescale 1ns/1ps
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int unsigned DW     = 9,
  parameter int unsigned AW     = 4,
  parameter int unsigned AE_OFS = 3
) (
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft,
  input  logic          ren,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          out_valid,
  output logic          almost_empty
);
  localparam int unsigned PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  rd_mode_e      mode;
  logic [PW-1:0] rbin_q, rgray_q, wbin_s, rbin_nx, occ_nx, n_off_q;
  logic          empty_q, ov_q, ov_nx, pop, ae_q;
  logic [DW-1:0] rdata_q;

  assign mode = rd_mode_e'(fwft);

  always_comb begin
    wbin_s = from_gray(wgray_s);
    if (mode == RD_FALLTHRU) begin
      pop   = !empty_q && (!ov_q || ren);
      ov_nx = pop ? 1'b1 : (ren ? 1'b0 : ov_q);
    end else begin
      pop   = ren && !empty_q;
      ov_nx = 1'b0;
    end
    rbin_nx = rbin_q + PW'(pop);
    occ_nx  = wbin_s - rbin_nx;
  end

  always_ff @(posedge rclk or negedge mrst_n) begin
    if (!mrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
      ov_q    <= 1'b0;
      ae_q    <= 1'b1;
      rdata_q <= '0;
      n_off_q <= PW'(AE_OFS);
    end else if (!prst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
      ov_q    <= 1'b0;
      ae_q    <= 1'b1;
      rdata_q <= '0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= to_gray(rbin_nx);
      empty_q <= (wbin_s == rbin_nx);
      ov_q    <= ov_nx;
      ae_q    <= !above(32'(occ_nx) + 32'(ov_nx), 32'(n_off_q));
      if (pop) rdata_q <= mem_q;
    end
  end

  assign raddr        = rbin_q[AW-1:0];
  assign rgray        = rgray_q;
  assign rdata        = rdata_q;
  assign empty        = empty_q;
  assign out_valid    = ov_q;
  assign almost_empty = ae_q;
endmodule

// File: rtl/dual_clock_fifo.sv
`timescale 1ns/1ps
module dual_clock_fifo #(
  parameter int unsigned DW          = 9,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned AE_OFS      = 3,
  parameter int unsigned AF_OFS      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          rd_stat_n,
  output logic          wr_stat_n,
  output logic          almost_empty,
  output logic          half_full,
  output logic          almost_full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  // named internal events, also observed by the bound checker
  logic          w_accept, w_full, r_empty, r_ovalid;
  logic [PW-1:0] w_ptr, w_gray, r_gray, w_gray_s, r_gray_s;
  logic [AW-1:0] w_addr, r_addr;
  logic [DW-1:0] mem_q;

  dcfifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .AF_OFS(AF_OFS)) u_wr (
    .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .wen(wen),
    .rgray_s(r_gray_s), .accept(w_accept), .waddr(w_addr), .wgray(w_gray),
    .wbin(w_ptr), .full(w_full), .half_full(half_full), .almost_full(almost_full)
  );

  dcfifo_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .wclk(wclk), .we(w_accept), .waddr(w_addr), .wdata(wdata),
    .raddr(r_addr), .rdata(mem_q)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .arst_n(mrst_n), .clr_n(prst_n), .d(w_gray), .q(w_gray_s)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .arst_n(mrst_n), .clr_n(prst_n), .d(r_gray), .q(r_gray_s)
  );

  dcfifo_rd_ctl #(.DW(DW), .AW(AW), .AE_OFS(AE_OFS)) u_rd (
    .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft(fwft), .ren(ren),
    .wgray_s(w_gray_s), .mem_q(mem_q), .raddr(r_addr), .rgray(r_gray),
    .rdata(rdata), .empty(r_empty), .out_valid(r_ovalid),
    .almost_empty(almost_empty)
  );

  // status pins change meaning with the read mode
  assign rd_stat_n = fwft ? ~r_ovalid : ~r_empty;
  assign wr_stat_n = fwft ? w_full : ~w_full;
endmodule

// File: rtl/dual_clock_fifo_checker.sv
`timescale 1ns/1ps
module dual_clock_fifo_checker #(
  parameter int unsigned DW = 9,
  parameter int unsigned PW = 5
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst_n,
  input logic          prst_n,
  input logic          fwft,
  input logic          wen,
  input logic          ren,
  input logic          w_full,
  input logic [PW-1:0] w_ptr,
  input logic          r_empty,
  input logic          r_ovalid,
  input logic [DW-1:0] rdata,
  input logic          rd_stat_n,
  input logic          wr_stat_n,
  input logic          almost_empty,
  input logic          half_full,
  input logic          almost_full
);
  // R7: a write while full leaves the write pointer where it was
  assert_full_hold_R7: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
    (w_full && wen) |=> $stable(w_ptr));

  // R9 and R8: a full array is also past both fill thresholds
  assert_full_thresholds_R9: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
    w_full |-> (almost_full && half_full));

  // R3: a standard-mode read while empty keeps the output word
  assert_empty_read_R3: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
    (!fwft && r_empty && ren) |=> $stable(rdata));

  // R2: no read request, no change of output in standard mode
  assert_std_hold_R2: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
    (!fwft && !ren) |=> $stable(rdata));

  // R5: a shown fall-through word stays until it is read
  assert_fwft_hold_R5: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
    (fwft && r_ovalid && !ren) |=> (r_ovalid && $stable(rdata)));

  // R11: read-side flags after a partial reset
  assert_prst_rd_R11: assert property (@(posedge rclk) disable iff (!mrst_n)
    !prst_n |=> (rd_stat_n == fwft && almost_empty));

  // R11: write-side flags after a partial reset
  assert_prst_wr_R11: assert property (@(posedge wclk) disable iff (!mrst_n)
    !prst_n |=> (wr_stat_n == !fwft && !half_full && !almost_full));
endmodule

bind dual_clock_fifo dual_clock_fifo_checker #(.DW(DW), .PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft(fwft),
  .wen(wen), .ren(ren), .w_full(w_full), .w_ptr(w_ptr), .r_empty(r_empty),
  .r_ovalid(r_ovalid), .rdata(rdata), .rd_stat_n(rd_stat_n),
  .wr_stat_n(wr_stat_n), .almost_empty(almost_empty), .half_full(half_full),
  .almost_full(almost_full)
);

// File: tb/dual_clock_fifo_test.sv
`timescale 1ns/1ps
module dual_clock_fifo_test;
  localparam int DW = 9, DEPTH = 16, AE = 3, AF = 4;

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst_n, prst_n, fwft, wen, ren;
  logic [DW-1:0] wdata, rdata;
  logic rd_stat_n, wr_stat_n, almost_empty, half_full, almost_full;

  always #2.5 wclk = ~wclk;     // 200 MHz write clock
  always #3.55 rclk = ~rclk;    // unrelated read clock

  dual_clock_fifo #(.DW(DW), .DEPTH(DEPTH), .AE_OFS(AE), .AF_OFS(AF)) uut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft(fwft),
    .wen(wen), .wdata(wdata), .ren(ren), .rdata(rdata), .rd_stat_n(rd_stat_n),
    .wr_stat_n(wr_stat_n), .almost_empty(almost_empty), .half_full(half_full),
    .almost_full(almost_full)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] model[$];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk);
    repeat (10) @(negedge wclk);
  endtask

  task automatic master_reset(input logic mode);
    mrst_n = 1'b0; prst_n = 1'b1; wen = 1'b0; ren = 1'b0; wdata = '0; fwft = mode;
    repeat (4) @(negedge rclk);
    @(negedge wclk) mrst_n = 1'b1;
    model.delete();
    settle();
  endtask

  task automatic wr1(input logic [DW-1:0] v, input bit taken);
    @(negedge wclk) begin wen = 1'b1; wdata = v; end
    @(negedge wclk) wen = 1'b0;
    if (taken) model.push_back(v);
  endtask

  task automatic rd_pulse();
    @(negedge rclk) ren = 1'b1;
    @(negedge rclk) ren = 0;
  endtask

  // write one word and count read edges until rd_stat_n reaches target
  task automatic wr_count(input logic [DW-1:0] v, input logic target, output int n);
    @(negedge wclk) begin wen = 1'b1; wdata = v; end
    @(posedge wclk);
    #0.1 wen = 1'b0;
    model.push_back(v);
    n = 0;
    while (rd_stat_n != target && n < 12) begin
      @(posedge rclk);
      #0.1 n++;
    end
  endtask

  task automatic t_reset();
    master_reset(1'b0);
    chk("R12", "std rd_stat_n", rd_stat_n, 0);
    chk("R12", "std wr_stat_n", wr_stat_n, 1);
    chk("R12", "almost_empty", almost_empty, 1);
    chk("R12", "half_full", half_full, 0);
    chk("R12", "almost_full", almost_full, 0);
    chk("R12", "rdata", rdata, 0);
    master_reset(1'b1);
    chk("R12", "fwft rd_stat_n", rd_stat_n, 1);
    chk("R12", "fwft wr_stat_n", wr_stat_n, 0);
  endtask

  task automatic t_std_latency();
    int n;
    master_reset(1'b0);
    wr_count(9'h15A, 1'b1, n);
    chk("R4", "empty release edges in 3..4", int'(n >= 3 && n <= 4), 1);
    chk("R2", "rdata before read", rdata, 0);
    rd_pulse();
    chk("R2", "first read", rdata, model.pop_front());
    settle();
    chk("R1", "empty after read", rd_stat_n, 0);
    rd_pulse();
    chk("R3", "rdata after empty read", rdata, 9'h15A);
    chk("R3", "still empty", rd_stat_n, 0);
  endtask

  task automatic t_std_order();
    master_reset(1'b0);
    for (int i = 0; i < 5; i++) wr1(9'(37 * i + 5), 1'b1);
    settle();
    for (int i = 0; i < 5; i++) begin
      rd_pulse();
      chk("R2", "ordered read", rdata, model.pop_front());
    end
  endtask

  task automatic t_std_full();
    master_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) wr1(9'(i * 29 + 3), 1'b1);
    wr1(9'h1FF, 1'b0);
    wr1(9'h1FE, 1'b0);
    settle();
    chk("R1", "full flag", wr_stat_n, 0);
    chk("R8", "half_full at full", half_full, 1);
    chk("R9", "almost_full at full", almost_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd_pulse();
      chk("R7", "stored word", rdata, model.pop_front());
    end
    settle();
    chk("R7", "dropped words absent", rd_stat_n, 0);
    chk("R1", "not full after drain", wr_stat_n, 1);
  endtask

  task automatic t_thresholds();
    master_reset(1'b0);
    for (int k = 1; k <= DEPTH; k++) begin
      wr1(9'(k * 11), 1'b1);
      settle();
      chk("R10", $sformatf("almost_empty k=%0d", k), almost_empty, int'(k <= AE));
      chk("R8", $sformatf("half_full k=%0d", k), half_full, int'(k > DEPTH / 2));
      chk("R9", $sformatf("almost_full k=%0d", k), almost_full, int'(k >= DEPTH - AF));
    end
    for (int k = 0; k < DEPTH; k++) begin
      rd_pulse();
      chk("R2", "drain word", rdata, model.pop_front());
    end
  endtask

  task automatic t_fwft_latency();
    int n;
    master_reset(1'b1);
    wr_count(9'h0C3, 1'b0, n);
    chk("R5", "ready edges in 4..5", int'(n >= 4 && n <= 5), 1);
    chk("R5", "word falls through", rdata, model.pop_front());
    rd_pulse();
    settle();
    chk("R5", "not ready after read", rd_stat_n, 1);
  endtask

  task automatic t_fwft_capacity();
    master_reset(1'b1);
    for (int k = 1; k <= AE + 1; k++) begin
      wr1(9'(k + 100), 1'b1);
      settle();
      chk("R10", $sformatf("fwft almost_empty k=%0d", k), almost_empty, int'(k <= AE));
    end
    for (int k = AE + 2; k <= DEPTH + 1; k++) wr1(9'(k + 100), 1'b1);
    wr1(9'h1AA, 1'b0);
    settle();
    chk("R6", "input not ready at DEPTH+1", wr_stat_n, 1);
    for (int i = 0; i <= DEPTH; i++) begin
      chk("R6", "output ready", rd_stat_n, 0);
      chk("R6", "fall-through word", rdata, model.pop_front());
      rd_pulse();
    end
    settle();
    chk("R6", "drained", rd_stat_n, 1);
    chk("R6", "input ready", wr_stat_n, 0);
  endtask

  task automatic t_partial(input logic mode);
    master_reset(mode);
    for (int i = 0; i < 10; i++) wr1(9'(i + 200), 1'b1);
    settle();
    @(negedge wclk) prst_n = 1'b0;
    repeat (6) @(negedge rclk);
    @(negedge wclk) prst_n = 1'b1;
    model.delete();
    settle();
    chk("R11", "rd_stat_n", rd_stat_n, int'(mode));
    chk("R11", "wr_stat_n", wr_stat_n, int'(!mode));
    chk("R11", "almost_empty", almost_empty, 1);
    chk("R11", "half_full", half_full, 0);
    chk("R11", "almost_full", almost_full, 0);
    for (int i = 0; i < AE; i++) wr1(9'(i + 50), 1'b1);
    settle();
    chk("R11", "offset kept, at AE", almost_empty, 1);
    wr1(9'h07F, 1'b1);
    settle();
    chk("R11", "offset kept, above AE", almost_empty, 0);
    if (!mode) rd_pulse();
    chk("R11", "first word after reset", rdata, model.pop_front());
  endtask

  initial begin
    t_reset();
    t_std_latency();
    t_std_order();
    t_std_full();
    t_thresholds();
    t_fwft_latency();
    t_fwft_capacity();
    t_partial(1'b0);
    t_partial(1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule